// File: doc/BRIEF.md
# Synchronous Serial Shift Port

This block moves one 4-bit or 8-bit word at a time across a clocked serial link. Outgoing bits leave on a serial-out pin and incoming bits enter on a serial-in pin, both timed by a shift clock. The shift clock is either produced here by dividing the system clock (master role) or taken from an external pin (slave role). Which edge of the shift clock does the shifting is chosen by software. The serial-out pin can also be turned around to serve as the data input, so a single wire can carry data both ways.

Software reaches the block through a small register interface. It writes a configuration word and a transmit word, then writes the start command. A busy flag covers the transfer. When it ends, a done flag rises and the received word can be read back. Reading that word, or starting a new transfer, clears the done flag. Bits move most significant first. A short transfer uses only the low nibble of the data register.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, status reads 0 (busy bit 0, done bit 1 both clear), the configuration reads 0, `sck_o` is high, and both `sck_oe` and `so_oe` are high.
- R2: Register address 0 holds the configuration and reads back what was written. Bit 0 selects long words (1 = 8 bits, 0 = 4 bits). Bit 1 selects the external clock. Bit 2 selects the falling edge as the active edge (0 = rising). Bit 3 turns the serial-out pin into the input. Bits 7:4 hold the clock divider. Address 1 is the data register. Writing 1 to bit 0 of address 2 starts a transfer. Reading address 2 gives busy in bit 0 and done in bit 1.
- R3: In 8-bit mode the word written to address 1 leaves MSB first on `so_o`, one bit per active edge. The bits sampled at the active edges form the word read back from address 1, MSB first.
- R4: In 4-bit mode only bits 3:0 of the data register are sent, MSB (bit 3) first. After the transfer, address 1 reads the four received bits in 3:0 and zeros in 7:4.
- R5: With the internal clock, `sck_o` idles high. A transfer gives exactly N low pulses (N = 4 or 8), and every high and low phase lasts divider+1 system clocks.
- R6: Every shift, both input sampling and output update, happens only at the selected active edge of the shift clock.
- R7: With the external clock, `sck_oe` is low. Shifting follows the edges of `sck_i` after synchronisation, and the transfer ends at the N-th active edge.
- R8: When the serial-out pin is configured as the input, `so_oe` is low and data is sampled from `so_i` instead of `si_i`.
- R9: Busy is set by start and stays set until the transfer completes. Done is then set and busy cleared in the same cycle. Done clears when address 1 is read or a new transfer is started.
- R10: While busy, writes to the configuration, to the data register and of the start command have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears done on data read) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| sck_i | input | 1 | External shift clock |
| sck_o | output | 1 | Generated shift clock |
| sck_oe | output | 1 | Output enable of the shift clock pin |
| si_i | input | 1 | Serial data input |
| so_i | input | 1 | Serial-out pin read back when used as input |
| so_o | output | 1 | Serial data output |
| so_oe | output | 1 | Output enable of the serial-out pin |

## Verification
A wrong bit counter or edge decode appears at the ports at once. It shows as a wrong number of `sck_o` pulses, or as busy dropping one active edge early or late, so the captured serial word comes out shifted by a bit. A fault in the shift register shows on `so_o` at the next active edge and in the word read back after done. A stuck done or busy flag is seen on the first status read after the transfer ends or after the data read.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    typedef enum logic [1:0] {
        REG_CFG  = 2'd0,
        REG_DATA = 2'd1,
        REG_CMD  = 2'd2,
        REG_NONE = 2'd3
    } ssp_reg_e;

    localparam int unsigned STAT_BUSY = 0;
    localparam int unsigned STAT_DONE = 1;
    localparam int unsigned CMD_START = 0;
endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
    parameter int unsigned WORD_W      = 8,
    parameter int unsigned SHORT_W     = 4,
    parameter int unsigned DIV_W       = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic             ext,
    input  logic             fall,
    input  logic             len_long,
    input  logic [DIV_W-1:0] div,
    input  logic             sck_i,
    output logic             sck_o,
    output logic             shift_en,
    output logic             int_fin
);
    localparam int unsigned CNT_W = $clog2(2 * WORD_W + 1);
    localparam logic [CNT_W-1:0] TGT_LONG  = CNT_W'(2 * WORD_W);
    localparam logic [CNT_W-1:0] TGT_SHORT = CNT_W'(2 * SHORT_W);
    localparam int unsigned TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [DIV_W-1:0]       divc;
        logic [CNT_W-1:0]       tog;
        logic                   sck;
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } clk_st_t;

    clk_st_t s_d, s_q;
    logic    ext_rise, ext_fall;
    logic [CNT_W-1:0] tgt;

    always_comb begin
        s_d      = s_q;
        shift_en = 1'b0;
        int_fin  = 1'b0;
        tgt      = len_long ? TGT_LONG : TGT_SHORT;

        // external clock: synchronise and keep one stage for edge detection
        s_d.sync = {s_q.sync[SYNC_STAGES-2:0], sck_i};
        s_d.prev = s_q.sync[TOP];
        ext_rise = s_q.sync[TOP] & ~s_q.prev;
        ext_fall = ~s_q.sync[TOP] & s_q.prev;

        if (start) begin
            s_d.divc = div;
            s_d.tog  = '0;
            s_d.sck  = 1'b1;
        end else if (run && !ext) begin
            if (s_q.divc == '0) begin
                s_d.divc = div;
                s_d.sck  = ~s_q.sck;
                s_d.tog  = s_q.tog + CNT_W'(1);
                shift_en = fall ? s_q.sck : ~s_q.sck;
                int_fin  = (s_q.tog + CNT_W'(1)) == tgt;
            end else begin
                s_d.divc = s_q.divc - DIV_W'(1);
            end
        end else if (!run) begin
            s_d.sck = 1'b1;
        end

        if (run && ext) begin
            shift_en = fall ? ext_fall : ext_rise;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{divc: '0, tog: '0, sck: 1'b1, sync: '1, prev: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    assign sck_o = s_q.sck;
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
    parameter int unsigned WORD_W  = 8,
    parameter int unsigned SHORT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] wdata,
    input  logic              start,
    input  logic              shift_en,
    input  logic              len_long,
    input  logic              din,
    output logic              sout,
    output logic [WORD_W-1:0] data,
    output logic              last
);
    localparam int unsigned BCNT_W = $clog2(WORD_W);
    localparam logic [BCNT_W-1:0] LAST_LONG  = BCNT_W'(WORD_W - 1);
    localparam logic [BCNT_W-1:0] LAST_SHORT = BCNT_W'(SHORT_W - 1);

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [BCNT_W-1:0] bitn;
    } sh_st_t;

    sh_st_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        last = shift_en && (s_q.bitn == (len_long ? LAST_LONG : LAST_SHORT));
        if (start) begin
            s_d.bitn = '0;
        end
        if (shift_en) begin
            s_d.bitn = s_q.bitn + BCNT_W'(1);
            if (len_long) begin
                s_d.data = {s_q.data[WORD_W-2:0], din};
            end else begin
                s_d.data = '0;
                s_d.data[SHORT_W-1:0] = {s_q.data[SHORT_W-2:0], din};
            end
        end else if (load) begin
            s_d.data = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sout = len_long ? s_q.data[WORD_W-1] : s_q.data[SHORT_W-1];
    assign data = s_q.data;
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
    import ssp_pkg::*;
#(
    parameter int unsigned WORD_W      = 8,
    parameter int unsigned SHORT_W     = 4,
    parameter int unsigned DIV_W       = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              si_i,
    input  logic              so_i,
    output logic              so_o,
    output logic              so_oe
);
    localparam int unsigned CFG_W = DIV_W + 4;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             bidir;
        logic             fall;
        logic             ext;
        logic             len_long;
    } cfg_t;

    typedef struct packed {
        cfg_t cfg;
        logic busy;
        logic done;
    } top_st_t;

    top_st_t  st_d, st_q;
    ssp_reg_e reg_sel;
    logic     wr_idle, cfg_we, data_we, start;
    logic     shift_en, int_fin, last, din, xfer_end;
    logic [WORD_W-1:0] rx_data;

    // plain views for the bound checker
    logic busy, done, cfg_ext, cfg_bidir;

    assign reg_sel = ssp_reg_e'(bus_addr);
    assign wr_idle = bus_wr && !st_q.busy;
    assign cfg_we  = wr_idle && (reg_sel == REG_CFG);
    assign data_we = wr_idle && (reg_sel == REG_DATA);
    assign start   = wr_idle && (reg_sel == REG_CMD) && bus_wdata[CMD_START];
    assign din     = st_q.cfg.bidir ? so_i : si_i;
    assign xfer_end = st_q.busy && (st_q.cfg.ext ? last : int_fin);

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            st_d.cfg = cfg_t'(bus_wdata[CFG_W-1:0]);
        end
        if (start) begin
            st_d.busy = 1'b1;
            st_d.done = 1'b0;
        end
        if (xfer_end) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
        end else if (bus_rd && (reg_sel == REG_DATA)) begin
            st_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (reg_sel)
            REG_CFG:  bus_rdata = WORD_W'(st_q.cfg);
            REG_DATA: bus_rdata = rx_data;
            REG_CMD: begin
                bus_rdata[STAT_BUSY] = st_q.busy;
                bus_rdata[STAT_DONE] = st_q.done;
            end
            default:  bus_rdata = '0;
        endcase
    end

    ssp_clkgen #(
        .WORD_W(WORD_W), .SHORT_W(SHORT_W), .DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)
    ) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .run      (st_q.busy),
        .ext      (st_q.cfg.ext),
        .fall     (st_q.cfg.fall),
        .len_long (st_q.cfg.len_long),
        .div      (st_q.cfg.div),
        .sck_i    (sck_i),
        .sck_o    (sck_o),
        .shift_en (shift_en),
        .int_fin  (int_fin)
    );

    ssp_shifter #(
        .WORD_W(WORD_W), .SHORT_W(SHORT_W)
    ) u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (data_we),
        .wdata    (bus_wdata),
        .start    (start),
        .shift_en (shift_en),
        .len_long (st_q.cfg.len_long),
        .din      (din),
        .sout     (so_o),
        .data     (rx_data),
        .last     (last)
    );

    assign sck_oe    = ~st_q.cfg.ext;
    assign so_oe     = ~st_q.cfg.bidir;
    assign busy      = st_q.busy;
    assign done      = st_q.done;
    assign cfg_ext   = st_q.cfg.ext;
    assign cfg_bidir = st_q.cfg.bidir;
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic ext,
    input logic bidir,
    input logic sck_o,
    input logic so_oe,
    input logic shift_en
);
    // R5: generated clock rests high whenever no internal transfer runs
    a_r5_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ext) |-> sck_o);

    // R7: generator stays quiet while an external clock drives the transfer
    a_r7_ext_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ext) |=> $stable(sck_o));

    // R9: the two status flags never overlap
    a_r9_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R9: done only rises at the end of a running transfer
    a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    // R8: pin turned around stays undriven through the transfer
    a_r8_bidir_released: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bidir) |-> !so_oe);

    // R6: no shifting outside a transfer
    a_r6_no_idle_shift: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !shift_en);
endmodule

bind sync_serial_port ssp_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .ext      (cfg_ext),
    .bidir    (cfg_bidir),
    .sck_o    (sck_o),
    .so_oe    (so_oe),
    .shift_en (shift_en)
);

// File: tb/sync_serial_port_tb.sv
module sync_serial_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       sck_i = 1'b1;
    logic       sck_o, sck_oe;
    logic       si_i = 1'b0;
    logic       so_i = 1'b0;
    logic       so_o, so_oe;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sync_serial_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .si_i(si_i),
        .so_i(so_i), .so_o(so_o), .so_oe(so_oe)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic peek(logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic pop_data(output logic [7:0] v);
        @(negedge clk);
        bus_addr = 2'd1; bus_rd = 1'b1;
        #1;
        v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic drive_din(logic bidir, logic b);
        if (bidir) begin so_i = b; si_i = ~b; end
        else begin si_i = b; so_i = ~b; end
    endtask

    // clocks n bits from the bench side on sck_i, capturing so_o before each active edge
    task automatic ext_clock_bits(int n, logic fall, logic bidir, logic [7:0] rxpat,
                                  output logic [7:0] cap);
        cap = 8'h00;
        for (int k = 0; k < n; k++) begin
            if (!fall) begin sck_i = 1'b0; repeat (6) @(negedge clk); end
            cap = {cap[6:0], so_o};
            drive_din(bidir, rxpat[n-1-k]);
            sck_i = fall ? 1'b0 : 1'b1;
            repeat (6) @(negedge clk);
            if (fall) begin sck_i = 1'b1; repeat (6) @(negedge clk); end
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        peek(2'd2, v); check("R1", "status after reset", v, 0);
        peek(2'd0, v); check("R1", "config after reset", v, 0);
        check("R1", "sck_o idle", sck_o, 1);
        check("R1", "sck_oe", sck_oe, 1);
        check("R1", "so_oe", so_oe, 1);
    endtask

    task automatic run_internal(logic len8, logic fall, logic bidir, logic [3:0] div,
                                logic [7:0] tx, logic [7:0] rxpat);
        int n = len8 ? 8 : 4;
        logic [7:0] cfgv = {div, bidir, fall, 1'b0, len8};
        logic [7:0] v, cap;
        logic [7:0] exp_tx = len8 ? tx : {4'h0, tx[3:0]};
        logic [7:0] exp_rx = len8 ? rxpat : {4'h0, rxpat[3:0]};
        logic prev_sck, prev_so;
        int k = 0, falls = 0, gap = 0, gap_bad = 0, guard = 0, oe_bad = 0;
        bus_write(2'd0, cfgv);
        peek(2'd0, v); check("R2", "config readback", v, cfgv);
        bus_write(2'd1, tx);
        drive_din(bidir, rxpat[n-1]);
        bus_write(2'd2, 8'h01);
        peek(2'd2, v); check("R9", "busy after start", v, 8'h01);
        cap = 8'h00;
        prev_sck = sck_o; prev_so = so_o;
        while (guard < 5000) begin
            @(negedge clk); #1;
            guard++; gap++;
            if (so_oe != !bidir) oe_bad++;
            if (sck_o != prev_sck) begin
                if (gap != int'(div) + 1) gap_bad++;
                gap = 0;
                if (!sck_o) falls++;
                if ((fall && !sck_o) || (!fall && sck_o)) begin
                    cap = {cap[6:0], prev_so};
                    k++;
                    if (k < n) drive_din(bidir, rxpat[n-1-k]);
                end
            end
            prev_sck = sck_o; prev_so = so_o;
            peek(2'd2, v);
            if (!v[0]) break;
        end
        check("R5", "pulse count", falls, n);
        check("R5", "half periods off", gap_bad, 0);
        check("R5", "sck_o idle after", sck_o, 1);
        check("R8", "so_oe during transfer", oe_bad, 0);
        check(len8 ? "R3" : "R4", "word sent on so_o", cap & (len8 ? 8'hFF : 8'h0F), exp_tx);
        check("R6", "active edges", k, n);
        peek(2'd2, v); check("R9", "done after end", v, 8'h02);
        pop_data(v); check(len8 ? "R3" : "R4", "received word", v, exp_rx);
        peek(2'd2, v); check("R9", "done cleared by read", v, 8'h00);
    endtask

    task automatic run_external(logic len8, logic fall, logic bidir, logic [7:0] tx,
                                logic [7:0] rxpat, logic meddle);
        int n = len8 ? 8 : 4;
        logic [7:0] cfgv = {4'h0, bidir, fall, 1'b1, len8};
        logic [7:0] v, cap, cap2;
        logic [7:0] exp_tx = len8 ? tx : {4'h0, tx[3:0]};
        logic [7:0] exp_rx = len8 ? rxpat : {4'h0, rxpat[3:0]};
        bus_write(2'd0, cfgv);
        bus_write(2'd1, tx);
        drive_din(bidir, rxpat[n-1]);
        bus_write(2'd2, 8'h01);
        check("R7", "sck_oe in external mode", sck_oe, 0);
        if (meddle) begin
            ext_clock_bits(2, fall, bidir, rxpat >> (n - 2), cap);
            bus_write(2'd0, 8'hF0);
            bus_write(2'd1, 8'h00);
            bus_write(2'd2, 8'h01);
            peek(2'd0, v); check("R10", "config write ignored while busy", v, cfgv);
            peek(2'd2, v); check("R10", "still busy after writes", v, 8'h01);
            ext_clock_bits(n - 2, fall, bidir, rxpat, cap2);
            cap = (cap << (n - 2)) | cap2;
        end else begin
            ext_clock_bits(n, fall, bidir, rxpat, cap);
        end
        check("R7", "sck_o untouched", sck_o, 1);
        check(len8 ? "R3" : "R4", "ext word sent", cap & (len8 ? 8'hFF : 8'h0F), exp_tx);
        peek(2'd2, v); check("R7", "done after N active edges", v, 8'h02);
        pop_data(v); check(bidir ? "R8" : "R3", "ext received word", v, exp_rx);
    endtask

    task automatic t_start_clears_done();
        logic [7:0] v, cap;
        bus_write(2'd0, 8'h02);
        bus_write(2'd1, 8'h09);
        drive_din(1'b0, 1'b1);
        bus_write(2'd2, 8'h01);
        ext_clock_bits(4, 1'b0, 1'b0, 8'h0B, cap);
        peek(2'd2, v); check("R9", "done set before restart", v, 8'h02);
        bus_write(2'd1, 8'h06);
        drive_din(1'b0, 1'b0);
        bus_write(2'd2, 8'h01);
        peek(2'd2, v); check("R9", "restart clears done", v, 8'h01);
        ext_clock_bits(4, 1'b0, 1'b0, 8'h04, cap);
        check("R4", "second short word sent", cap & 8'h0F, 8'h06);
        pop_data(v); check("R4", "second short word received", v, 8'h04);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_internal(1'b1, 1'b0, 1'b0, 4'd2, 8'hA5, 8'h3C);
        run_internal(1'b0, 1'b1, 1'b0, 4'd0, 8'hB6, 8'h09);
        run_internal(1'b1, 1'b1, 1'b1, 4'd5, 8'h81, 8'h7E);
        run_external(1'b1, 1'b0, 1'b0, 8'h5A, 8'hC3, 1'b0);
        run_external(1'b0, 1'b1, 1'b1, 8'h0D, 8'h0A, 1'b1);
        t_start_clears_done();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule